// File: doc/BRIEF.md
# Key-Value Reduce Scratchpad

This block takes the place of a software reduce stage. Producers present (key, value) pairs one per cycle. The block finds the table slot for each key, either by folding the key down to the index width or by using the low key bits as the index. On a hit it reduces the value into the stored entry. On a miss to an empty slot it installs the key. A pair whose slot already holds a different key is dropped and reported on a status output.

Each entry holds the full key, a tag byte, and a running value. The tag byte is a valid bit plus a 7-bit saturating occurrence count. In sum mode the value reported for a key is the running total. In average mode it is the running total divided by the occurrence count, with the quotient truncated.

A drain command walks the table and emits every valid entry with an end-of-sequence flag. A clear command empties the table in one cycle. The table is 2K entries by default; the index width is a parameter.

Top module: `kv_reduce_pad`

## Requirements
- R1: During and right after reset, `in_ready` is 1, `out_valid` is 0 and `collide` is 0. After reset the table is empty.
- R2: With `cfg_avg`=0 (sum mode), the first accepted pair for a key installs the key with its value and a count of 1. Every later pair for that key adds its value to the stored value, modulo 2^32.
- R3: With `cfg_avg`=1 (average mode), a drained entry carries `out_val` = stored sum / `out_cnt` (integer, truncated) and `out_cnt` = the number of pairs reduced into it.
- R4: The occurrence count saturates at 127. Further pairs still add to the sum but leave the count at 127.
- R5: With `cfg_direct`=0 (hashed), the slot is the XOR of the key cut into IDX_W-bit chunks starting at bit 0, with the top chunk zero-padded.
- R6: With `cfg_direct`=1 (direct), the slot is `in_key[IDX_W-1:0]`. The full key is still stored and compared.
- R7: If the slot is valid and holds a different key, the pair is dropped and the stored entry is left unchanged. `collide` is 1 for exactly one cycle, namely the cycle after the second rising edge that follows acceptance.
- R8: Pairs accepted on consecutive cycles, whether for the same key or for alternating keys, are all reduced without loss.
- R9: A one-cycle `clr` invalidates every entry, discards a pair still in flight and aborts a drain. A later drain then emits nothing.
- R10: `drain_go` while `in_ready`=1 starts a drain. `in_ready` is 0 from the next cycle until the drain ends. Valid entries come out on cycles with `out_valid`=1 in ascending slot order. `out_last`=1 marks only the final one. An empty table emits nothing and `in_ready` returns to 1.
- R11: A pair presented while `in_ready`=0 is ignored and does not change the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_avg | input | 1 | 1: average reduce, 0: sum reduce |
| cfg_direct | input | 1 | 1: key low bits index the table, 0: folded key indexes it |
| in_valid | input | 1 | Pair present |
| in_key | input | KEY_W | Pair key |
| in_val | input | VAL_W | Pair value |
| in_ready | output | 1 | Pairs are accepted this cycle |
| clr | input | 1 | Invalidate all entries |
| drain_go | input | 1 | Start a drain of all valid entries |
| collide | output | 1 | A pair was dropped on a key clash |
| out_valid | output | 1 | Drained entry present |
| out_last | output | 1 | Final drained entry |
| out_key | output | KEY_W | Drained key |
| out_val | output | VAL_W | Drained sum or average |
| out_cnt | output | CNT_W | Drained occurrence count |

## Verification
The bench builds the block with IDX_W=3, which gives an 8-slot table. With so few slots, a few small keys are enough to land on the same folded slot, so clashes can be provoked on purpose. The few slots also keep a full drain walk to under a dozen cycles. Keys are chosen so that hashed and direct addressing place them in different orders, which lets the drain order tell the two modes apart. KEY_W, VAL_W and CNT_W keep their defaults, so count saturation at 127 is reached with 130 pairs.

// File: rtl/kv_reduce_pad.sv
module kv_reduce_pad #(
  parameter int KEY_W = 64,
  parameter int VAL_W = 32,
  parameter int IDX_W = 11,
  parameter int CNT_W = 7
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_avg,
  input  logic             cfg_direct,
  input  logic             in_valid,
  input  logic [KEY_W-1:0] in_key,
  input  logic [VAL_W-1:0] in_val,
  output logic             in_ready,
  input  logic             clr,
  input  logic             drain_go,
  output logic             collide,
  output logic             out_valid,
  output logic             out_last,
  output logic [KEY_W-1:0] out_key,
  output logic [VAL_W-1:0] out_val,
  output logic [CNT_W-1:0] out_cnt
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int NCH   = (KEY_W + IDX_W - 1) / IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  typedef enum logic [1:0] {S_IDLE, S_FLUSH, S_SCAN} st_t;
  st_t st;

  logic [KEY_W-1:0] m_key [DEPTH];
  logic [VAL_W-1:0] m_sum [DEPTH];
  logic [CNT_W-1:0] m_cnt [DEPTH];
  logic [DEPTH-1:0] vld;

  function automatic logic [IDX_W-1:0] fold(input logic [KEY_W-1:0] k);
    logic [NCH*IDX_W-1:0] pad;
    logic [IDX_W-1:0]     h;
    pad = '0;
    pad[KEY_W-1:0] = k;
    h = '0;
    for (int i = 0; i < NCH; i++) h ^= pad[i*IDX_W +: IDX_W];
    return h;
  endfunction

  logic [IDX_W-1:0] in_idx;
  logic             accept;
  assign in_idx   = cfg_direct ? in_key[IDX_W-1:0] : fold(in_key);
  assign in_ready = (st == S_IDLE);
  assign accept   = in_valid && in_ready && !clr;

  logic             p1_v, p1_svld;
  logic [KEY_W-1:0] p1_key, p1_skey;
  logic [VAL_W-1:0] p1_val, p1_ssum;
  logic [CNT_W-1:0] p1_scnt;
  logic [IDX_W-1:0] p1_idx;

  logic             hit, clash, wr, fwd;
  logic [VAL_W-1:0] w_sum;
  logic [CNT_W-1:0] w_cnt;
  assign hit   = p1_svld && (p1_skey == p1_key);
  assign clash = p1_svld && !hit;
  assign wr    = p1_v && !clash && !clr;
  assign w_sum = hit ? p1_ssum + p1_val : p1_val;
  assign w_cnt = !hit ? CNT_ONE : (p1_scnt == CNT_MAX) ? p1_scnt : p1_scnt + CNT_ONE;
  assign fwd   = wr && (p1_idx == in_idx);

  always_ff @(posedge clk) begin
    if (wr) begin
      m_key[p1_idx] <= p1_key;
      m_sum[p1_idx] <= w_sum;
      m_cnt[p1_idx] <= w_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld <= '0;
    else if (clr)   vld <= '0;
    else if (wr)    vld[p1_idx] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_v    <= 1'b0;
      collide <= 1'b0;
    end else begin
      p1_v    <= accept;
      collide <= p1_v && clash && !clr;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      p1_key  <= in_key;
      p1_val  <= in_val;
      p1_idx  <= in_idx;
      p1_skey <= fwd ? p1_key : m_key[in_idx];
      p1_ssum <= fwd ? w_sum  : m_sum[in_idx];
      p1_scnt <= fwd ? w_cnt  : m_cnt[in_idx];
      p1_svld <= fwd ? 1'b1   : vld[in_idx];
    end
  end

  logic [IDX_W-1:0] ptr;
  logic             last_here;
  logic [VAL_W-1:0] rd_avg;
  assign last_here = ((vld >> ptr) >> 1) == '0;
  assign rd_avg    = m_sum[ptr] / {{(VAL_W-CNT_W){1'b0}}, m_cnt[ptr]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ptr       <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (clr) st <= S_IDLE;
      else begin
        case (st)
          S_IDLE:  if (drain_go) st <= S_FLUSH;
          S_FLUSH: if (!p1_v) begin
                     st  <= S_SCAN;
                     ptr <= '0;
                   end
          S_SCAN: begin
            ptr <= ptr + 1'b1;
            if (vld[ptr]) begin
              out_valid <= 1'b1;
              out_last  <= last_here;
            end
            if ((vld[ptr] && last_here) || (&ptr)) st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_SCAN && vld[ptr]) begin
      out_key <= m_key[ptr];
      out_val <= cfg_avg ? rd_avg : m_sum[ptr];
      out_cnt <= m_cnt[ptr];
    end
  end
endmodule

// File: rtl/kv_reduce_pad_chk.sv
module kv_reduce_pad_chk #(
  parameter int CNT_W = 7
)(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             clr,
  input logic             drain_go,
  input logic             collide,
  input logic             out_valid,
  input logic             out_last,
  input logic [CNT_W-1:0] out_cnt
);
  assert_last_framed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_busy_on_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_go && in_ready && !clr) |=> !in_ready);

  assert_count_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cnt != '0));

  assert_collide_has_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    collide |-> $past(in_valid && in_ready, 2));

  assert_clear_quiets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (in_ready && !out_valid && !collide));
endmodule

bind kv_reduce_pad kv_reduce_pad_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .clr(clr), .drain_go(drain_go), .collide(collide),
  .out_valid(out_valid), .out_last(out_last), .out_cnt(out_cnt)
);

// File: tb/tb_kv_reduce_pad.sv
module tb_kv_reduce_pad;
  localparam int KW = 64, VW = 32, IW = 3, CW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_avg = 1'b0, cfg_direct = 1'b0;
  logic in_valid = 1'b0;
  logic [KW-1:0] in_key = '0;
  logic [VW-1:0] in_val = '0;
  logic clr = 1'b0, drain_go = 1'b0;
  logic in_ready, collide, out_valid, out_last;
  logic [KW-1:0] out_key;
  logic [VW-1:0] out_val;
  logic [CW-1:0] out_cnt;

  always #4 clk = ~clk;

  kv_reduce_pad #(.KEY_W(KW), .VAL_W(VW), .IDX_W(IW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_avg(cfg_avg), .cfg_direct(cfg_direct),
    .in_valid(in_valid), .in_key(in_key), .in_val(in_val), .in_ready(in_ready),
    .clr(clr), .drain_go(drain_go), .collide(collide),
    .out_valid(out_valid), .out_last(out_last), .out_key(out_key),
    .out_val(out_val), .out_cnt(out_cnt)
  );

  int n_run = 0, n_fail = 0;
  int n_cap;
  logic [KW-1:0] cap_key [16];
  logic [VW-1:0] cap_val [16];
  logic [CW-1:0] cap_cnt [16];
  logic          cap_last [16];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [KW-1:0] k, input logic [VW-1:0] v);
    in_valid = 1'b1; in_key = k; in_val = v;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic drain(input bit poke);
    drain_go = 1'b1;
    @(negedge clk);
    drain_go = 1'b0;
    n_cap = 0;
    for (int i = 0; i < 40; i++) begin
      if (poke && i == 1) begin
        check("R10 in_ready low while draining", 64'(in_ready), 64'd0);
        in_valid = 1'b1; in_key = 64'h7; in_val = 32'd100;
      end else if (poke && i == 2) begin
        in_key = 64'h5; in_val = 32'd1;
      end else begin
        in_valid = 1'b0;
      end
      if (out_valid && n_cap < 16) begin
        cap_key[n_cap] = out_key; cap_val[n_cap] = out_val;
        cap_cnt[n_cap] = out_cnt; cap_last[n_cap] = out_last;
        n_cap++;
      end
      if (in_ready) break;
      @(negedge clk);
    end
    in_valid = 1'b0;
    check("R10 in_ready back after drain", 64'(in_ready), 64'd1);
  endtask

  task automatic expect_entry(input string tag, input int i, input logic [KW-1:0] k,
                              input logic [VW-1:0] v, input int c, input bit last);
    check({tag, " key"},  cap_key[i], k);
    check({tag, " val"},  64'(cap_val[i]), 64'(v));
    check({tag, " cnt"},  64'(cap_cnt[i]), 64'(c));
    check({tag, " last"}, 64'(cap_last[i]), 64'(last));
  endtask

  task automatic t_reset();
    check("R1 ready in reset", 64'(in_ready), 64'd1);
    check("R1 out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 collide after reset", 64'(collide), 64'd0);
    drain(1'b0);
    check("R1 empty after reset", 64'(n_cap), 64'd0);
  endtask

  // R5: slots 0x41->0, 0x2->2, 0x100->4, 0x5->5 under folding
  task automatic t_sum_hashed();
    do_clear();
    cfg_avg = 1'b0; cfg_direct = 1'b0;
    send(64'h5, 32'd10); @(negedge clk);
    send(64'h2, 32'd3);  @(negedge clk);
    send(64'h100, 32'd1); @(negedge clk);
    send(64'h41, 32'd8); @(negedge clk);
    send(64'h5, 32'd7);  @(negedge clk);
    @(negedge clk);
    drain(1'b0);
    check("R2 R5 entry count", 64'(n_cap), 64'd4);
    expect_entry("R5 slot0", 0, 64'h41, 32'd8, 1, 1'b0);
    expect_entry("R5 slot2", 1, 64'h2, 32'd3, 1, 1'b0);
    expect_entry("R5 slot4", 2, 64'h100, 32'd1, 1, 1'b0);
    expect_entry("R2 slot5 sum", 3, 64'h5, 32'd17, 2, 1'b1);
  endtask

  // R6: direct slots 0x21->1, 0x13->3, 0x6->6
  task automatic t_avg_direct();
    do_clear();
    cfg_avg = 1'b1; cfg_direct = 1'b1;
    send(64'h13, 32'd10); @(negedge clk);
    send(64'h6, 32'd7);   @(negedge clk);
    send(64'h13, 32'd20); @(negedge clk);
    send(64'h21, 32'd9);  @(negedge clk);
    send(64'h6, 32'd8);   @(negedge clk);
    send(64'h13, 32'd31); @(negedge clk);
    @(negedge clk);
    drain(1'b0);
    check("R3 R6 entry count", 64'(n_cap), 64'd3);
    expect_entry("R6 slot1", 0, 64'h21, 32'd9, 1, 1'b0);
    expect_entry("R3 slot3 avg", 1, 64'h13, 32'd20, 3, 1'b0);
    expect_entry("R3 slot6 avg trunc", 2, 64'h6, 32'd7, 2, 1'b1);
  endtask

  task automatic t_back_to_back();
    do_clear();
    cfg_avg = 1'b0; cfg_direct = 1'b1;
    send(64'h1, 32'd1); send(64'h2, 32'd10); send(64'h1, 32'd2);
    send(64'h2, 32'd20); send(64'h1, 32'd3); send(64'h1, 32'd4);
    send(64'h1, 32'd5);
    @(negedge clk); @(negedge clk);
    drain(1'b0);
    check("R8 entry count", 64'(n_cap), 64'd2);
    expect_entry("R8 same key run", 0, 64'h1, 32'd15, 5, 1'b0);
    expect_entry("R8 alternating", 1, 64'h2, 32'd30, 2, 1'b1);
  endtask

  // keys 1 and 8 both fold to slot 1
  task automatic t_collide();
    do_clear();
    cfg_avg = 1'b0; cfg_direct = 1'b0;
    send(64'h1, 32'd4);
    send(64'h8, 32'd9);
    check("R7 no collide for install", 64'(collide), 64'd0);
    @(negedge clk);
    check("R7 collide pulse", 64'(collide), 64'd1);
    @(negedge clk);
    check("R7 collide one cycle", 64'(collide), 64'd0);
    drain(1'b0);
    check("R7 entry count", 64'(n_cap), 64'd1);
    expect_entry("R7 entry kept", 0, 64'h1, 32'd4, 1, 1'b1);
  endtask

  task automatic t_saturate();
    do_clear();
    cfg_avg = 1'b0; cfg_direct = 1'b1;
    for (int i = 0; i < 130; i++) send(64'h2, 32'd1);
    @(negedge clk); @(negedge clk);
    drain(1'b0);
    check("R4 entry count", 64'(n_cap), 64'd1);
    expect_entry("R4 saturated", 0, 64'h2, 32'd130, 127, 1'b1);
  endtask

  task automatic t_clear();
    cfg_avg = 1'b0; cfg_direct = 1'b1;
    send(64'h4, 32'd1); @(negedge clk); @(negedge clk);
    do_clear();
    drain(1'b0);
    check("R9 empty after clear", 64'(n_cap), 64'd0);
    send(64'h3, 32'd1);
    do_clear();
    @(negedge clk);
    drain(1'b0);
    check("R9 in-flight pair discarded", 64'(n_cap), 64'd0);
  endtask

  task automatic t_ignore();
    do_clear();
    cfg_avg = 1'b0; cfg_direct = 1'b1;
    send(64'h7, 32'd1); @(negedge clk); @(negedge clk);
    drain(1'b1);
    check("R10 first drain count", 64'(n_cap), 64'd1);
    @(negedge clk);
    drain(1'b0);
    check("R11 count unchanged", 64'(n_cap), 64'd1);
    expect_entry("R11 entry untouched", 0, 64'h7, 32'd1, 1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_sum_hashed();
    t_avg_direct();
    t_back_to_back();
    t_collide();
    t_saturate();
    t_clear();
    t_ignore();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule